// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers a small set of interrupt request lines, up to six of them, behind one byte-wide register. Each input passes through a rising-edge detector. An edge on an enabled line latches a pending flag for that line. At the same register address, a bus write loads the enable mask and a bus read returns the pending flags of the enabled lines. A single interrupt output stays high while any enabled line has a pending flag.

Software does not acknowledge a source by writing ones to it. It clears a pending flag by dropping that line's enable bit. A typical service loop reads the status and, for every set bit, writes an enable mask with those bits removed. It repeats until the status reads zero, then writes the original mask back. An edge that arrives during this loop on a line that is still enabled sets its own flag, so a later read in the loop picks it up. A build-time mask decides which source bits exist. Bits outside the mask are not implemented: they read as zero and writes to them have no effect.

Top module: `intsrc_regblock`

## Requirements
- R1: After synchronous reset, all enables and pending flags are zero, `irq` is 0 and `rd_data` is 0.
- R2: A write with `wr_en` high and `addr` equal to `REG_OFFSET` (default 5'h1E) loads the enable of source i from `wr_data[i]` for i in 0 to NSRC-1. The new enables apply from the next clock edge.
- R3: Source i gets a pending flag when `src_in[i]` goes from 0 to 1 while its enable is 1. This uses the enable held before any write in that same cycle.
- R4: A read with `rd_en` high at `REG_OFFSET` puts the pending flags in `rd_data[NSRC-1:0]` one cycle later, with the upper bits set to zero. At any other time, including a read at another address, `rd_data` is 0.
- R5: `irq` is a register. It goes high one cycle after any enabled source becomes pending. It goes low one cycle after the last pending flag is cleared.
- R6: Writing 0 to an enable bit clears that source's pending flag at the same edge. Writing 1 to an enable bit that is already set leaves its pending flag unchanged, so there is no write-one-to-clear.
- R7: An edge on a disabled source is lost. This includes an edge in the same cycle as the write that disables the source. Enabling the source later does not create a pending flag, and neither does an input held high.
- R8: A write to any address other than `REG_OFFSET` changes neither the enables nor the pending flags.
- R9: Source bits that are clear in `VALID_MASK` are not implemented. They read as 0, ignore writes and never raise `irq`.
- R10: An edge on an enabled source while other flags are pending sets its flag as well. A later read returns the union of the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data, the enable mask |
| rd_data | output | DATA_W | Registered read data, the status of enabled pending sources |
| src_in | input | NSRC | Interrupt source levels, sampled for rising edges |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong enable bit would show up on the next edge of that source. The following read would return a wrong status bit, and `irq` would be wrong one cycle after the edge. A pending flag that stays set or gets lost would appear on the next read at the register address. It would also keep `irq` high or low one cycle longer or shorter than expected after the clearing write. The sweep applies every enable mask with all sources pulsed, and then reads and clears. Any stuck or crossed bit therefore shows up within a handful of cycles of the mask that exposes it.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e decode_access(input logic wr, input logic rd,
                                              input logic hit);
    if (hit && wr)      return ACC_WRITE;
    else if (hit && rd) return ACC_READ;
    else                return ACC_NONE;
  endfunction
endpackage

// File: rtl/intsrc_edge.sv
module intsrc_edge #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/intsrc_cell.sv
module intsrc_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic rise,
  output logic en_q,
  output logic pend_q
);
  generate
    if (IMPL) begin : g_impl
      logic en_next;
      assign en_next = wr_hit ? wr_bit : en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          en_q   <= en_next;
          // Edge qualified by the enable held before this cycle's write;
          // a cleared enable wipes the flag at the same edge.
          pend_q <= en_next & (pend_q | (rise & en_q));
        end
      end
    end else begin : g_absent
      assign en_q   = 1'b0;
      assign pend_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/intsrc_any.sv
module intsrc_any #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  output logic         any_q
);
  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |(pend & en);
  end
endmodule

// File: rtl/intsrc_regblock.sv
module intsrc_regblock #(
  parameter int               NSRC       = 6,
  parameter int               DATA_W     = 8,
  parameter int               ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 5'h1E,
  parameter logic [NSRC-1:0]  VALID_MASK = 6'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq
);
  import intsrc_pkg::*;

  localparam int PAD_W = DATA_W - NSRC;

  acc_kind_e        acc;
  logic             wr_hit;
  logic             rd_hit;
  logic [NSRC-1:0]  rise_vec;
  logic [NSRC-1:0]  en_vec;
  logic [NSRC-1:0]  pend_vec;
  logic [DATA_W-1:0] status_word;

  assign acc    = decode_access(wr_en, rd_en, addr == REG_OFFSET);
  assign wr_hit = (acc == ACC_WRITE);
  assign rd_hit = (acc == ACC_READ);

  intsrc_edge #(.W(NSRC)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (src_in),
    .rise (rise_vec)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    intsrc_cell #(.IMPL(VALID_MASK[i])) u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (wr_hit),
      .wr_bit (wr_data[i]),
      .rise   (rise_vec[i]),
      .en_q   (en_vec[i]),
      .pend_q (pend_vec[i])
    );
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_word = {{PAD_W{1'b0}}, pend_vec & en_vec};
    end else begin : g_nopad
      assign status_word = pend_vec & en_vec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= status_word;
    else             rd_data <= '0;
  end

  intsrc_any #(.W(NSRC)) u_any (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_vec),
    .en    (en_vec),
    .any_q (irq)
  );
endmodule

// File: rtl/intsrc_regblock_chk.sv
module intsrc_regblock_chk #(
  parameter int               NSRC       = 6,
  parameter int               DATA_W     = 8,
  parameter int               ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 5'h1E,
  parameter logic [NSRC-1:0]  VALID_MASK = 6'h3F
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   pend,
  input logic              irq
);
  localparam logic [DATA_W-1:0] VALID_EXT = DATA_W'(VALID_MASK);

  // R4: no read at the register means quiet read data
  p_quiet_rdata_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == REG_OFFSET) |=> (rd_data == '0));

  // R9: unimplemented bits never read back as 1
  p_invalid_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~VALID_EXT) == '0);

  // R6: dropping an enable clears its flag
  p_disable_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OFFSET) |=> ((pend & ~$past(wr_data[NSRC-1:0])) == '0));

  // R6: writing one keeps a pending flag
  p_no_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OFFSET) |=>
      ((pend & $past(pend) & $past(wr_data[NSRC-1:0])) ==
       ($past(pend) & $past(wr_data[NSRC-1:0]))));

  // R7: a flag only appears on a source enabled in the previous cycle
  p_no_set_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

  // R8: foreign writes leave the enables alone
  p_foreign_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != REG_OFFSET) |=> (en == $past(en)));

  // R5: writing an all-zero mask drops irq two edges later
  p_irq_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OFFSET && wr_data[NSRC-1:0] == '0) |=> ##1 !irq);
endmodule

bind intsrc_regblock intsrc_regblock_chk #(
  .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REG_OFFSET(REG_OFFSET), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .en(en_vec), .pend(pend_vec),
  .irq(irq)
);

// File: tb/intsrc_regblock_bench.sv
module intsrc_regblock_bench;
  localparam int         NSRC  = 6;
  localparam int         DW    = 8;
  localparam int         AW    = 5;
  localparam logic [AW-1:0] OFF = 5'h1E;
  localparam logic [NSRC-1:0] VMASK = 6'h2F; // bit 4 not implemented

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NSRC-1:0] src_in = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intsrc_regblock #(
    .NSRC(NSRC), .DATA_W(DW), .ADDR_W(AW), .REG_OFFSET(OFF), .VALID_MASK(VMASK)
  ) u_intsrc_regblock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .src_in(src_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] p);
    @(negedge clk); src_in = p;
    @(negedge clk); src_in = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 rd_data", rd_data, 8'd0);
    pulse(6'h3F);                 // all disabled after reset
    rd(OFF);
    chk("R1 status", rd_data, 8'd0);

    // R2 R3 R5 R6 R9: sweep every enable mask with all sources pulsed
    for (int m = 0; m < 64; m++) begin
      logic [NSRC-1:0] exp_v;
      exp_v = 6'(m) & VMASK;
      wr(OFF, DW'(m));
      pulse(6'h3F);
      @(negedge clk);
      chk("R5 irq after edge", {7'd0, irq}, {7'd0, exp_v != 0});
      rd(OFF);
      chk("R3 status", rd_data, {2'b00, exp_v});
      @(negedge clk);
      chk("R4 quiet", rd_data, 8'd0);
      wr(OFF, 8'h00);
      @(negedge clk);
      chk("R5 irq cleared", {7'd0, irq}, 8'd0);
      rd(OFF);
      chk("R6 cleared", rd_data, 8'd0);
    end

    // R9: upper data bits and the absent source
    wr(OFF, 8'hFF);
    pulse(6'h3F);
    rd(OFF);
    chk("R9 upper masked", rd_data, 8'h2F);
    wr(OFF, 8'h10);
    pulse(6'h10);
    @(negedge clk);
    chk("R9 absent no irq", {7'd0, irq}, 8'd0);
    rd(OFF);
    chk("R9 absent reads 0", rd_data, 8'd0);

    // R10 and R6: service loop accumulation and no write-one-to-clear
    wr(OFF, 8'h03);
    pulse(6'h01);
    rd(OFF);
    chk("R10 first", rd_data, 8'h01);
    pulse(6'h02);
    rd(OFF);
    chk("R10 union", rd_data, 8'h03);
    wr(OFF, 8'h03);
    rd(OFF);
    chk("R6 no w1c", rd_data, 8'h03);
    wr(OFF, 8'h02);
    rd(OFF);
    chk("R6 partial clear", rd_data, 8'h02);
    chk("R5 irq held", {7'd0, irq}, 8'd1);

    // R8: foreign write and foreign read
    wr(5'h00, 8'h00);
    rd(5'h1D);
    chk("R4 foreign read", rd_data, 8'd0);
    rd(OFF);
    chk("R8 foreign write", rd_data, 8'h02);
    wr(OFF, 8'h00);

    // R7: edge lost while disabled, re-enable creates nothing
    pulse(6'h01);
    wr(OFF, 8'h01);
    rd(OFF);
    chk("R7 lost edge", rd_data, 8'd0);
    // R7: edge in the same cycle as the disabling write
    @(negedge clk); wr_en = 1'b1; addr = OFF; wr_data = 8'h00; src_in = 6'h01;
    @(negedge clk); wr_en = 1'b0; src_in = '0;
    wr(OFF, 8'h01);
    rd(OFF);
    chk("R7 same-cycle disable", rd_data, 8'd0);
    // R7: held level then enable
    wr(OFF, 8'h00);
    @(negedge clk); src_in = 6'h04;
    @(negedge clk);
    wr(OFF, 8'h04);
    rd(OFF);
    chk("R7 held level", rd_data, 8'd0);
    @(negedge clk);
    chk("R7 no irq", {7'd0, irq}, 8'd0);
    src_in = '0;

    // R1: reset mid-run
    wr(OFF, 8'h01);
    pulse(6'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {7'd0, irq}, 8'd0);
    rd(OFF);
    chk("R1 status after reset", rd_data, 8'd0);

    finish_run();
  end
endmodule